// File: doc/BRIEF.md
# Queue-Threshold Workload Reallocation Controller

This controller balances the work of a multi-core packet processing grid that serves three applications. Each application has its own packet queue. Each processor core runs one application at a time. The controller holds one table entry per core: the application the core currently runs, its expected service time, its utilisation and its workload. It compares every queue's fill level against a programmable threshold. When a queue is too long, the controller takes one core away from a lightly loaded application and gives it to the overloaded one. Only the new task number has to reach that core, because every task sits at a fixed place in instruction memory.

New packets are steered through a second, per-application table. Each entry of that table holds the set of cores serving the application. The set is copied from the per-core entries only at a fixed, programmable interval. A packet-side lookup returns that set combinationally for a given application. Whenever any queue is above threshold, the controller raises a warning and captures all three queue lengths alongside it.

Top module: `wrc_realloc_ctrl`

## Requirements
- R1: After reset, core c runs application c mod 3. Every core's utilisation is all-ones (15, meaning fully utilised) and its service time is 1, so all workloads start equal. The move and warning outputs are 0.
- R2: An application is overloaded only when its queue length is strictly greater than the threshold input. A length equal to the threshold is not overloaded.
- R3: One clock after any queue is sampled above threshold, the warning output is 1 and the captured lengths output holds all three queue lengths, application a in bits [8a+7:8a]. The warning returns to 0 one clock after no queue is above threshold.
- R4: A report (valid, core index, utilisation, service time) sets that core's workload to utilisation × service time. Among the cores that qualify, the donor is the one with the smallest workload; on a tie, the lowest core index wins.
- R5: A donor core never comes from an application that is itself overloaded. It is also never the only core left running its application.
- R6: When an overloaded application finds no qualifying donor, the warning is still raised and no move is issued.
- R7: A move is a one-clock pulse on the move-valid output, one clock after the overload is sampled. It carries the donor core index and the new task (the overloaded application's ID). From then on, that core counts as running the new task.
- R8: After a move for an application, the next move for that same application comes no sooner than refresh-interval + 1 clocks later.
- R9: The packet row table changes only once every refresh-interval clocks. At each such point it takes the current core-to-application assignment. A move that lands between two such points is not visible in the table before the next point.
- R10: The row output gives the core set for the application on the packet-application input, combinationally, with bit c set when core c serves it. The reset sets are 9, 18 and 36 for applications 0, 1 and 2. An application ID of 3 returns 0.
- R11: When several applications are overloaded and not blocked by R8, the lowest application ID is served first, and only one move is made per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| q_len_i | input | 3x8 | Queue length per application |
| thresh_i | input | 8 | Overload threshold |
| intv_i | input | 16 | Refresh interval and reassignment hold-off, in clocks |
| rpt_vld_i | input | 1 | Utilisation report strobe |
| rpt_core_i | input | 3 | Core the report is for |
| rpt_util_i | input | 4 | Reported utilisation |
| rpt_svc_i | input | 4 | Reported expected service time |
| pkt_app_i | input | 2 | Application ID of a new packet |
| pkt_row_o | output | 6 | Core set serving that application |
| mv_vld_o | output | 1 | Move pulse |
| mv_core_o | output | 3 | Donor core being switched |
| mv_task_o | output | 2 | Task ID the donor core now runs |
| warn_o | output | 1 | Overload warning |
| warn_qlen_o | output | 3x8 | Queue lengths captured with the warning |

## Verification
The assertions assume that the refresh interval is held constant between resets and is at least 2. The hold-off check relies on this. They also assume that report core indices name a real core. The stimulus meets both assumptions: it sets the interval to 20 before each reset and never changes it while running, and it addresses reports only to cores 0 to 5. The queue lengths are driven well inside their width. The threshold is held at 4 throughout, so the strict-greater boundary can be checked at exactly 4 and 5.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

  // default geometry of the controller
  localparam int unsigned WRC_APPS  = 3;
  localparam int unsigned WRC_CORES = 6;

  // outcome of one reallocation decision
  typedef enum logic [1:0] {
    DEC_IDLE    = 2'd0,
    DEC_MOVE    = 2'd1,
    DEC_NODONOR = 2'd2
  } wrc_dec_e;

  // application a core runs right after reset
  function automatic int unsigned home_app(input int unsigned core, input int unsigned apps);
    return core % apps;
  endfunction

endpackage

// File: rtl/wrc_res_table.sv
module wrc_res_table #(
  parameter int unsigned NA      = 3,
  parameter int unsigned NC      = 6,
  parameter int unsigned UW      = 4,
  parameter int unsigned SW      = 4,
  parameter int unsigned SVC_RST = 1,
  localparam int unsigned AW     = (NA > 1) ? $clog2(NA) : 1,
  localparam int unsigned CW     = (NC > 1) ? $clog2(NC) : 1,
  localparam int unsigned WW     = UW + SW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rpt_vld,
  input  logic [CW-1:0]          rpt_core,
  input  logic [UW-1:0]          rpt_util,
  input  logic [SW-1:0]          rpt_svc,
  input  logic                   mv_en,
  input  logic [CW-1:0]          mv_core,
  input  logic [AW-1:0]          mv_app,
  output logic [NC-1:0][AW-1:0]  task_o,
  output logic [NC-1:0][WW-1:0]  wl_o
);
  import wrc_pkg::*;

  localparam logic [UW-1:0] UTIL_FULL = '1;
  localparam logic [WW-1:0] WL_RST    = WW'(UTIL_FULL) * WW'(SVC_RST);

  for (genvar c = 0; c < NC; c++) begin : g_core
    logic [AW-1:0] task_d, task_q;
    logic [UW-1:0] util_d, util_q;
    logic [SW-1:0] svc_d, svc_q;
    logic [WW-1:0] wl_d, wl_q;
    logic          rpt_hit, mv_hit;

    always_comb begin
      rpt_hit = rpt_vld && (rpt_core == CW'(c));
      mv_hit  = mv_en && (mv_core == CW'(c));
      task_d  = mv_hit ? mv_app : task_q;
      util_d  = rpt_hit ? rpt_util : util_q;
      svc_d   = rpt_hit ? rpt_svc : svc_q;
      wl_d    = WW'(util_d) * WW'(svc_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        task_q <= AW'(home_app(c, NA));
        util_q <= UTIL_FULL;
        svc_q  <= SW'(SVC_RST);
        wl_q   <= WL_RST;
      end else begin
        if (mv_hit) task_q <= task_d;
        if (rpt_hit) begin
          util_q <= util_d;
          svc_q  <= svc_d;
          wl_q   <= wl_d;
        end
      end
    end

    assign task_o[c] = task_q;
    assign wl_o[c]   = wl_q;
  end

endmodule

// File: rtl/wrc_donor_pick.sv
module wrc_donor_pick #(
  parameter int unsigned NA  = 3,
  parameter int unsigned NC  = 6,
  parameter int unsigned WW  = 8,
  localparam int unsigned AW = (NA > 1) ? $clog2(NA) : 1,
  localparam int unsigned CW = (NC > 1) ? $clog2(NC) : 1,
  localparam int unsigned NW = CW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NC-1:0][AW-1:0]  task_i,
  input  logic [NC-1:0][WW-1:0]  wl_i,
  input  logic [NA-1:0]          over_i,
  output logic                   don_vld,
  output logic [CW-1:0]          don_core
);

  logic [NW-1:0] cnt [NA];
  logic [WW-1:0] best;
  logic          ok;

  // cores per application
  always_comb begin
    for (int a = 0; a < NA; a++) begin
      cnt[a] = '0;
      for (int c = 0; c < NC; c++) begin
        if (task_i[c] == AW'(a)) cnt[a] = cnt[a] + NW'(1);
      end
    end
  end

  // least loaded qualifying core, lowest index on ties
  always_comb begin
    don_vld  = 1'b0;
    don_core = '0;
    best     = '0;
    for (int c = 0; c < NC; c++) begin
      ok = (int'(task_i[c]) < NA) && !over_i[task_i[c]] && (cnt[task_i[c]] >= NW'(2));
      if (ok && (!don_vld || (wl_i[c] < best))) begin
        don_vld  = 1'b1;
        don_core = CW'(c);
        best     = wl_i[c];
      end
    end
  end

  // R5: donor application is not overloaded
  p_donor_not_hot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    don_vld |-> !over_i[task_i[don_core]]);

  // R5: donor application keeps at least one core
  p_donor_keeps_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    don_vld |-> (cnt[task_i[don_core]] >= NW'(2)));

endmodule

// File: rtl/wrc_task_map.sv
module wrc_task_map #(
  parameter int unsigned NA   = 3,
  parameter int unsigned NC   = 6,
  parameter int unsigned IW   = 16,
  localparam int unsigned AW  = (NA > 1) ? $clog2(NA) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IW-1:0]          intv_i,
  input  logic [NC-1:0][AW-1:0]  task_i,
  input  logic [AW-1:0]          q_app_i,
  output logic [NC-1:0]          q_row_o
);
  import wrc_pkg::*;

  logic [IW-1:0]         cnt_d, cnt_q, last;
  logic                  tick;
  logic [NA-1:0][NC-1:0] row_d, row_q;

  always_comb begin
    last  = (intv_i == '0) ? '0 : (intv_i - IW'(1));
    tick  = (cnt_q >= last);
    cnt_d = tick ? '0 : (cnt_q + IW'(1));
    for (int a = 0; a < NA; a++) begin
      for (int c = 0; c < NC; c++) begin
        row_d[a][c] = (task_i[c] == AW'(a));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int a = 0; a < NA; a++) begin
        for (int c = 0; c < NC; c++) begin
          row_q[a][c] <= (home_app(c, NA) == a);
        end
      end
    end else begin
      cnt_q <= cnt_d;
      if (tick) row_q <= row_d;
    end
  end

  assign q_row_o = (int'(q_app_i) < NA) ? row_q[q_app_i] : '0;

  // R9: after each refresh every core sits in exactly one row
  for (genvar c = 0; c < NC; c++) begin : g_col
    logic [NA-1:0] col;
    for (genvar a = 0; a < NA; a++) begin : g_bit
      assign col[a] = row_q[a][c];
    end
    p_core_single_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(col) == 1);
  end

endmodule

// File: rtl/wrc_realloc_ctrl.sv
module wrc_realloc_ctrl #(
  parameter int unsigned NUM_APPS  = wrc_pkg::WRC_APPS,
  parameter int unsigned NUM_CORES = wrc_pkg::WRC_CORES,
  parameter int unsigned QLEN_W    = 8,
  parameter int unsigned UTIL_W    = 4,
  parameter int unsigned SVC_W     = 4,
  parameter int unsigned INTV_W    = 16,
  parameter int unsigned SVC_RST   = 1,
  localparam int unsigned AW       = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
  localparam int unsigned CW       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned WW       = UTIL_W + SVC_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_APPS-1:0][QLEN_W-1:0]  q_len_i,
  input  logic [QLEN_W-1:0]                thresh_i,
  input  logic [INTV_W-1:0]                intv_i,
  input  logic                             rpt_vld_i,
  input  logic [CW-1:0]                    rpt_core_i,
  input  logic [UTIL_W-1:0]                rpt_util_i,
  input  logic [SVC_W-1:0]                 rpt_svc_i,
  input  logic [AW-1:0]                    pkt_app_i,
  output logic [NUM_CORES-1:0]             pkt_row_o,
  output logic                             mv_vld_o,
  output logic [CW-1:0]                    mv_core_o,
  output logic [AW-1:0]                    mv_task_o,
  output logic                             warn_o,
  output logic [NUM_APPS-1:0][QLEN_W-1:0]  warn_qlen_o
);
  import wrc_pkg::*;

  // reset: asserted at once, released on a clock edge
  logic rs1_q, rs2_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_core_n = rs2_q;

  logic [NUM_CORES-1:0][AW-1:0] task_w;
  logic [NUM_CORES-1:0][WW-1:0] wl_w;
  logic [NUM_APPS-1:0]          over;
  logic                         don_vld;
  logic [CW-1:0]                don_core;
  logic                         tgt_vld;
  logic [AW-1:0]                tgt_app;
  wrc_dec_e                     dec;
  logic                         mv_en;

  logic [NUM_APPS-1:0][INTV_W-1:0] cool_d, cool_q;
  logic                            mv_vld_d, mv_vld_q;
  logic [CW-1:0]                   mv_core_d, mv_core_q;
  logic [AW-1:0]                   mv_task_d, mv_task_q;
  logic                            warn_d, warn_q;
  logic [NUM_APPS-1:0][QLEN_W-1:0] wqlen_d, wqlen_q;

  // overload detection and target choice
  always_comb begin
    tgt_vld = 1'b0;
    tgt_app = '0;
    for (int a = 0; a < NUM_APPS; a++) begin
      over[a] = (q_len_i[a] > thresh_i);
      if (!tgt_vld && over[a] && (cool_q[a] == '0)) begin
        tgt_vld = 1'b1;
        tgt_app = AW'(a);
      end
    end
    if (!tgt_vld)     dec = DEC_IDLE;
    else if (don_vld) dec = DEC_MOVE;
    else              dec = DEC_NODONOR;
    mv_en = (dec == DEC_MOVE);
  end

  wrc_res_table #(
    .NA(NUM_APPS), .NC(NUM_CORES), .UW(UTIL_W), .SW(SVC_W), .SVC_RST(SVC_RST)
  ) u_table (
    .clk(clk), .rst_n(rst_core_n),
    .rpt_vld(rpt_vld_i), .rpt_core(rpt_core_i), .rpt_util(rpt_util_i), .rpt_svc(rpt_svc_i),
    .mv_en(mv_en), .mv_core(don_core), .mv_app(tgt_app),
    .task_o(task_w), .wl_o(wl_w)
  );

  wrc_donor_pick #(
    .NA(NUM_APPS), .NC(NUM_CORES), .WW(WW)
  ) u_pick (
    .clk(clk), .rst_n(rst_core_n),
    .task_i(task_w), .wl_i(wl_w), .over_i(over),
    .don_vld(don_vld), .don_core(don_core)
  );

  wrc_task_map #(
    .NA(NUM_APPS), .NC(NUM_CORES), .IW(INTV_W)
  ) u_map (
    .clk(clk), .rst_n(rst_core_n),
    .intv_i(intv_i), .task_i(task_w),
    .q_app_i(pkt_app_i), .q_row_o(pkt_row_o)
  );

  // next state of hold-off counters and outputs
  always_comb begin
    for (int a = 0; a < NUM_APPS; a++) begin
      if (mv_en && (tgt_app == AW'(a))) cool_d[a] = intv_i;
      else if (cool_q[a] != '0)        cool_d[a] = cool_q[a] - INTV_W'(1);
      else                             cool_d[a] = '0;
    end
    mv_vld_d  = mv_en;
    mv_core_d = don_core;
    mv_task_d = tgt_app;
    warn_d    = |over;
    wqlen_d   = q_len_i;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cool_q    <= '0;
      mv_vld_q  <= 1'b0;
      mv_core_q <= '0;
      mv_task_q <= '0;
      warn_q    <= 1'b0;
      wqlen_q   <= '0;
    end else begin
      cool_q   <= cool_d;
      mv_vld_q <= mv_vld_d;
      warn_q   <= warn_d;
      if (mv_en) begin
        mv_core_q <= mv_core_d;
        mv_task_q <= mv_task_d;
      end
      if (warn_d) wqlen_q <= wqlen_d;
    end
  end

  assign mv_vld_o    = mv_vld_q;
  assign mv_core_o   = mv_core_q;
  assign mv_task_o   = mv_task_q;
  assign warn_o      = warn_q;
  assign warn_qlen_o = wqlen_q;

  // R6: a move is only ever issued under a warning
  p_move_has_warn_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    mv_vld_q |-> warn_q);

  // R7: the moved core runs the announced task in the table
  p_move_in_table_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    mv_vld_q |-> (task_w[mv_core_q] == mv_task_q));

  // R8: no back-to-back moves for one application
  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mv_en && (intv_i > INTV_W'(1))) |=> !(mv_en && (tgt_app == $past(tgt_app))));

  // R11: at most one target per clock, and it is overloaded
  p_target_hot_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    mv_en |-> over[tgt_app]);

endmodule

// File: tb/tb_wrc_realloc_ctrl.sv
module tb_wrc_realloc_ctrl;

  localparam int INTV = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0][7:0]  q_len;
  logic [7:0]       thresh;
  logic [15:0]      intv;
  logic             rpt_vld;
  logic [2:0]       rpt_core;
  logic [3:0]       rpt_util;
  logic [3:0]       rpt_svc;
  logic [1:0]       pkt_app;
  logic [5:0]       pkt_row;
  logic             mv_vld;
  logic [2:0]       mv_core;
  logic [1:0]       mv_task;
  logic             warn;
  logic [2:0][7:0]  warn_qlen;

  int checks = 0;
  int failures = 0;
  int ecount = 0;
  int cyc = 0;
  int m_task [6];
  int m_util [6];
  int m_svc [6];

  always #5 clk = ~clk;

  wrc_realloc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .q_len_i(q_len), .thresh_i(thresh), .intv_i(intv),
    .rpt_vld_i(rpt_vld), .rpt_core_i(rpt_core), .rpt_util_i(rpt_util), .rpt_svc_i(rpt_svc),
    .pkt_app_i(pkt_app), .pkt_row_o(pkt_row), .mv_vld_o(mv_vld), .mv_core_o(mv_core),
    .mv_task_o(mv_task), .warn_o(warn), .warn_qlen_o(warn_qlen)
  );

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
    cyc <= cyc + 1;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int phase();
    return (ecount - 2) % INTV;
  endfunction

  function automatic int row_of(input int a);
    int r = 0;
    for (int c = 0; c < 6; c++) if (m_task[c] == a) r |= (1 << c);
    return r;
  endfunction

  function automatic int pick(input bit [2:0] ov);
    int cnt [3];
    int best = 0;
    int bc = -1;
    for (int a = 0; a < 3; a++) cnt[a] = 0;
    for (int c = 0; c < 6; c++) cnt[m_task[c]]++;
    for (int c = 0; c < 6; c++) begin
      int a = m_task[c];
      int w = m_util[c] * m_svc[c];
      if (!ov[a] && cnt[a] >= 2 && (bc < 0 || w < best)) begin
        bc = c;
        best = w;
      end
    end
    return bc;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; q_len = '0; thresh = 8'd4; intv = 16'(INTV);
    rpt_vld = 1'b0; rpt_core = '0; rpt_util = '0; rpt_svc = '0; pkt_app = '0;
    for (int c = 0; c < 6; c++) begin
      m_task[c] = c % 3; m_util[c] = 15; m_svc[c] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic row_chk(input string req, input int a, input int exp);
    pkt_app = 2'(a);
    #1;
    chk(req, $sformatf("row app%0d", a), pkt_row, exp);
  endtask

  task automatic wait_phase(input int ph);
    do @(negedge clk); while (phase() != ph);
  endtask

  // watchdog
  initial begin
    wait (cyc > 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gap;
    int pulses;
    int exp_core;
    do_reset();

    // R1 / R10: reset state
    chk("R1", "warn after reset", warn, 0);
    chk("R1", "move after reset", mv_vld, 0);
    row_chk("R10", 0, 9);
    row_chk("R10", 1, 18);
    row_chk("R10", 2, 36);
    row_chk("R10", 3, 0);

    // R2: equal to threshold is not overload
    q_len[0] = 8'd4;
    @(negedge clk);
    chk("R2", "warn at equal", warn, 0);
    chk("R2", "move at equal", mv_vld, 0);
    q_len[0] = 8'd0;

    // R2 R3 R7 R1 R4: above threshold, equal workloads
    wait_phase(2);
    q_len[0] = 8'd5;
    exp_core = pick(3'b001);
    @(negedge clk);
    chk("R3", "warn", warn, 1);
    chk("R3", "captured lengths", warn_qlen, 5);
    chk("R7", "move pulse", mv_vld, 1);
    chk("R4", "donor core (tie to lowest)", mv_core, exp_core);
    chk("R7", "move task", mv_task, 0);
    m_task[exp_core] = 0;

    // R8 / R9: hold-off spacing and row refresh only at interval points
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      if (phase() == 10 && gap < 10) row_chk("R9", 0, 9);
      if (phase() == 2 && gap < 21)  row_chk("R9", 0, row_of(0));
    end while (!mv_vld && gap < 60);
    chk("R8", "cycles between moves", gap, INTV + 1);
    exp_core = pick(3'b001);
    chk("R5", "second donor skips single-core app", mv_core, exp_core);
    m_task[exp_core] = 0;

    // R6: no donor remains
    pulses = 0;
    repeat (30) begin
      @(negedge clk);
      if (mv_vld) pulses++;
    end
    chk("R6", "moves without donor", pulses, 0);
    chk("R6", "warn held", warn, 1);
    wait_phase(2);
    row_chk("R9", 0, row_of(0));
    row_chk("R9", 1, row_of(1));
    row_chk("R9", 2, row_of(2));
    q_len = '0;
    @(negedge clk);
    chk("R3", "warn falls", warn, 0);

    // R11 / R5: two overloaded applications at once
    do_reset();
    q_len[1] = 8'd6;
    q_len[2] = 8'd7;
    @(negedge clk);
    chk("R11", "move pulse", mv_vld, 1);
    chk("R11", "lowest app first", mv_task, 1);
    chk("R5", "donor from cool app", mv_core, 0);
    chk("R3", "captured lengths", warn_qlen, (7 << 16) | (6 << 8));
    pulses = 0;
    repeat (40) begin
      @(negedge clk);
      if (mv_vld) pulses++;
    end
    chk("R5", "no further moves", pulses, 0);

    // R4: workload sweep over report patterns
    for (int p = 0; p < 12; p++) begin
      int tgt;
      do_reset();
      for (int c = 0; c < 6; c++) begin
        m_util[c] = (p * 7 + c * 5 + 3) % 16;
        m_svc[c]  = (p * 3 + c * 11 + 1) % 16;
        rpt_vld = 1'b1; rpt_core = 3'(c);
        rpt_util = 4'(m_util[c]); rpt_svc = 4'(m_svc[c]);
        @(negedge clk);
      end
      rpt_vld = 1'b0;
      tgt = p % 3;
      q_len[tgt] = 8'd9;
      exp_core = pick(3'(1 << tgt));
      @(negedge clk);
      chk("R4", $sformatf("sweep %0d move", p), mv_vld, 1);
      chk("R4", $sformatf("sweep %0d donor", p), mv_core, exp_core);
      chk("R7", $sformatf("sweep %0d task", p), mv_task, tgt);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule